// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives the command pins of a single-data-rate SDRAM from reset until the device is ready for normal traffic. It first waits for a stabilization-complete input, which is raised by logic elsewhere once the clock and supply have been steady for the required delay. It then runs a fixed command sequence: a one-cycle NOP state, a PRECHARGE that closes every bank, two AUTO REFRESH commands, and a LOAD MODE REGISTER. Every command lasts one cycle and is followed by a number of NOP cycles set by a parameter.

After the final wait, the block sets a sticky ready flag. The main controller can then take over the pins. All outputs come from registers. Clock enable stays high the whole time. A synchronous active-high reset restarts the sequence from the beginning.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is applied, and on the first cycle after it, the command pins {cs_n, ras_n, cas_n, we_n} show NOP (4'b0111) and init_done_o is 0.
- R2: While stable_i is low and the sequence has not started, the pins stay at NOP and init_done_o stays at 0.
- R3: PRECHARGE (4'b0010) appears on the pins exactly 3 cycles after the clock edge at which stable_i is first sampled high. Address bit 10 is 1 during that cycle, so all banks are selected.
- R4: The commands other than NOP appear in this order: PRECHARGE, AUTO REFRESH (4'b0001), AUTO REFRESH, LOAD MODE REGISTER (4'b0000). Each appears exactly once, and each is held for exactly one cycle.
- R5: Exactly T_RP NOP cycles separate PRECHARGE from the first AUTO REFRESH.
- R6: Exactly T_RFC NOP cycles follow each AUTO REFRESH before the next command.
- R7: During LOAD MODE REGISTER the address bus equals MODE_VAL and the bank address is 0. The default MODE_VAL selects burst length 1, sequential bursts and CAS latency 2.
- R8: init_done_o goes high on the cycle right after the T_MRD NOP cycles that follow LOAD MODE REGISTER. From then until reset it stays high and the pins stay at NOP.
- R9: Once the sequence has started, stable_i has no effect: dropping it does not stall, restart or change the command trace.
- R10: cke_o is 1 in every cycle.
- R11: A reset applied at any point in the sequence returns the pins to NOP and clears init_done_o on the next cycle. A full, correct sequence then follows the next assertion of stable_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stable_i | input | 1 | Clock/power stabilization delay has elapsed |
| cke_o | output | 1 | SDRAM clock enable, held high |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row address strobe, active low |
| cas_n_o | output | 1 | Column address strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| init_done_o | output | 1 | Initialization complete, sticky until reset |

## Verification
The bench builds the sequencer with T_RP=2, T_RFC=3 and T_MRD=1, and uses a non-default MODE_VAL of 13'h0C27 so that a wrong or zeroed mode word on the bus is detected. With these short waits, one full trace takes only about a dozen cycles. The bench can therefore sweep the idle delay before stable_i, the point at which stable_i is dropped, and a mid-sequence reset at every cycle offset of the trace. At each of those cycles it compares the pins against the expected slot positions, which it computes from the three wait parameters.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // FSM states of the start-up sequence
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_NOP,
    ST_PRE,
    ST_W_RP,
    ST_REF1,
    ST_W_RFC1,
    ST_REF2,
    ST_W_RFC2,
    ST_LMR,
    ST_W_MRD,
    ST_DONE
  } init_state_t;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001,
    CMD_LMR = 4'b0000
  } sdr_cmd_t;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  // R5/R6: an idle expired timer must not wrap around
  p_timer_rest_r6: assert property (@(posedge clk) disable iff (rst)
    (expired && !load) |=> expired);

  // R5: a nonzero count always moves toward zero
  p_timer_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
  import sdram_init_pkg::*;
#(
  parameter int              ADDR_W   = 13,
  parameter int              BA_W     = 2,
  parameter logic [ADDR_W-1:0] MODE_VAL = 13'h020
) (
  input  init_state_t       state,
  output sdr_cmd_t          cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  localparam int AP_BIT = 10;

  always_comb begin
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    unique case (state)
      ST_PRE: begin
        cmd          = CMD_PRE;
        addr[AP_BIT] = 1'b1;
      end
      ST_REF1, ST_REF2: cmd = CMD_REF;
      ST_LMR: begin
        cmd  = CMD_LMR;
        addr = MODE_VAL;
      end
      default: cmd = CMD_NOP;
    endcase
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int                ADDR_W   = 13,
  parameter int                BA_W     = 2,
  parameter int                T_RP     = 3,
  parameter int                T_RFC    = 9,
  parameter int                T_MRD    = 2,
  parameter logic [ADDR_W-1:0] MODE_VAL = 13'h020
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stable_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o
);

  localparam int T_MAX0 = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int T_MAX  = (T_MAX0 > T_MRD) ? T_MAX0 : T_MRD;
  localparam int CNT_W  = $clog2(T_MAX + 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(T_RFC - 1);
  localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 1);

  init_state_t       state_q, state_d;
  logic              tmr_load, tmr_exp;
  logic [CNT_W-1:0]  tmr_val;
  sdr_cmd_t          cmd_c, cmd_q;
  logic [BA_W-1:0]   ba_c, ba_q;
  logic [ADDR_W-1:0] addr_c, addr_q;
  logic              done_q;

  // next state and wait loading
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE:   if (stable_i) state_d = ST_NOP;
      ST_NOP:    state_d = ST_PRE;
      ST_PRE:    begin tmr_load = 1'b1; tmr_val = LD_RP;  state_d = ST_W_RP;   end
      ST_W_RP:   if (tmr_exp) state_d = ST_REF1;
      ST_REF1:   begin tmr_load = 1'b1; tmr_val = LD_RFC; state_d = ST_W_RFC1; end
      ST_W_RFC1: if (tmr_exp) state_d = ST_REF2;
      ST_REF2:   begin tmr_load = 1'b1; tmr_val = LD_RFC; state_d = ST_W_RFC2; end
      ST_W_RFC2: if (tmr_exp) state_d = ST_LMR;
      ST_LMR:    begin tmr_load = 1'b1; tmr_val = LD_MRD; state_d = ST_W_MRD;  end
      ST_W_MRD:  if (tmr_exp) state_d = ST_DONE;
      ST_DONE:   state_d = ST_DONE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  sdram_init_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  sdram_init_cmd_enc #(
    .ADDR_W   (ADDR_W),
    .BA_W     (BA_W),
    .MODE_VAL (MODE_VAL)
  ) enc_i (
    .state (state_q),
    .cmd   (cmd_c),
    .ba    (ba_c),
    .addr  (addr_c)
  );

  // registered pin stage
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_c;
      ba_q   <= ba_c;
      addr_q <= addr_c;
      done_q <= (state_q == ST_DONE);
    end
  end

  assign cke_o       = 1'b1;
  assign cs_n_o      = cmd_q[3];
  assign ras_n_o     = cmd_q[2];
  assign cas_n_o     = cmd_q[1];
  assign we_n_o      = cmd_q[0];
  assign ba_o        = ba_q;
  assign addr_o      = addr_q;
  assign init_done_o = done_q;

  // R2: no start without stabilization
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !stable_i) |=> (state_q == ST_IDLE));

  // R3: precharge on pins selects all banks
  p_pre_allbank_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE) |-> addr_o[10]);

  // R4: every command is a single cycle followed by NOP
  p_cmd_single_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NOP) |=> (cmd_q == CMD_NOP));

  // R7: mode word and bank on the load
  p_lmr_word_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_LMR) |-> (addr_o == MODE_VAL && ba_o == '0));

  // R8: ready is sticky and the bus is quiet afterwards
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    init_done_o |=> init_done_o);
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    init_done_o |-> (cmd_q == CMD_NOP));

  // R9: sequence never falls back to idle once begun
  p_no_fallback_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> (state_q != ST_IDLE));

endmodule

// File: tb/sdram_init_seq_tb_top.sv
module sdram_init_seq_tb_top;

  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  localparam int T_RP   = 2;
  localparam int T_RFC  = 3;
  localparam int T_MRD  = 1;
  localparam logic [ADDR_W-1:0] MODE_VAL = 13'h0C27;

  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] PRE = 4'b0010;
  localparam logic [3:0] REF = 4'b0001;
  localparam logic [3:0] LMR = 4'b0000;

  localparam int P_PRE  = 3;
  localparam int P_R1   = P_PRE + T_RP + 1;
  localparam int P_R2   = P_R1 + T_RFC + 1;
  localparam int P_LMR  = P_R2 + T_RFC + 1;
  localparam int P_DONE = P_LMR + T_MRD + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stable_i = 1'b0;
  logic cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, init_done_o;
  logic [BA_W-1:0]   ba_o;
  logic [ADDR_W-1:0] addr_o;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sdram_init_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .MODE_VAL(MODE_VAL)
  ) dut_i (
    .clk(clk), .rst(rst), .stable_i(stable_i), .cke_o(cke_o),
    .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
    .ba_o(ba_o), .addr_o(addr_o), .init_done_o(init_done_o)
  );

  function automatic logic [3:0] pins();
    return {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_cmd(input int k);
    if (k == P_PRE) return PRE;
    if (k == P_R1 || k == P_R2) return REF;
    if (k == P_LMR) return LMR;
    return NOP;
  endfunction

  task automatic quiet_check(input string req);
    check(pins() == NOP, req, 32'(pins()), 32'(NOP));
    check(init_done_o == 1'b0, req, 32'(init_done_o), 32'd0);
    check(cke_o == 1'b1, "R10", 32'(cke_o), 32'd1);
  endtask

  // rst_at: cycle of a mid-sequence reset (0 = none)
  task automatic run_seq(input int idle_cyc, input int drop_at, input int rst_at);
    @(negedge clk);
    rst = 1'b1; stable_i = 1'b0;
    @(negedge clk);
    quiet_check("R1");
    rst = 1'b0;
    @(negedge clk);
    quiet_check("R1");
    for (int i = 0; i < idle_cyc; i++) begin
      @(negedge clk);
      quiet_check("R2");
    end
    stable_i = 1'b1;
    for (int k = 1; k <= P_DONE + 3; k++) begin
      @(negedge clk);
      begin
        logic [3:0] e;
        string      r;
        e = exp_cmd(k);
        if (k == P_PRE)                    r = "R3";
        else if (k == P_LMR)               r = "R4";
        else if (k > P_PRE && k < P_R1)    r = "R5";
        else if (k > P_R1 && k < P_LMR)    r = "R6";
        else if (k > P_LMR)                r = "R8";
        else                               r = (drop_at != 0) ? "R9" : "R4";
        if (drop_at != 0 && k > drop_at)   r = {r, "/R9"};
        check(pins() == e, r, 32'(pins()), 32'(e));
        check(cke_o == 1'b1, "R10", 32'(cke_o), 32'd1);
        check(init_done_o == (k >= P_DONE), "R8", 32'(init_done_o), 32'(k >= P_DONE));
        if (k == P_PRE)
          check(addr_o[10] == 1'b1, "R3", 32'(addr_o), 32'h400);
        if (k == P_LMR) begin
          check(addr_o == MODE_VAL, "R7", 32'(addr_o), 32'(MODE_VAL));
          check(ba_o == '0, "R7", 32'(ba_o), 32'd0);
        end
      end
      if (k == drop_at) stable_i = 1'b0;
      if (k == rst_at) begin
        rst = 1'b1;
        @(negedge clk);
        quiet_check("R11");
        rst = 1'b0; stable_i = 1'b0;
        @(negedge clk);
        quiet_check("R11");
        return;
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    // R2: idle delays swept before stabilization
    for (int d = 0; d < 5; d++) run_seq(d, 0, 0);
    // R9: stable_i dropped at every point of the trace
    for (int q = 1; q <= P_DONE + 2; q++) run_seq(1, q, 0);
    // R11: reset at every cycle offset, then a clean full sequence
    for (int r = 1; r <= P_DONE + 2; r++) begin
      run_seq(2, 0, r);
      run_seq(0, 0, 0);
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule